// File: doc/BRIEF.md
# Manchester II Word Encoder

This block turns one word at a time into a Manchester II line signal. Each frame opens with a three-bit-time sync character, carries K data bits taken serially from the host, and closes with one parity bit. The result drives a complementary pair of line outputs. The block runs from a single clock at twice the bit rate, so every bit cell spans two clock cycles. A whole frame therefore occupies 2K+8 clock cycles.

The host raises `enable` to request a frame, and picks the sync type and parity sense before the frame starts. While `data_req` is high, the host supplies one bit per bit cell on `ser_din`. It changes the bit between rising edges, and the encoder samples it on the rising edge that opens the cell. If `enable` is still high at the last cycle of a frame, the next frame follows with no idle gap. A line-inhibit input forces both outputs high without disturbing the sequencing. A synchronous `abort` input drops the frame in progress and returns the block to idle.

Top module: `manchester_word_enc`

## Requirements
- R1: After reset and whenever the block is idle, `line_pos` and `line_neg` are both 0 and `data_req` is 0.
- R2: When `enable` is sampled high on a rising edge while idle, a frame starts. Its line pattern begins on the outputs one cycle later and lasts exactly 2K+8 consecutive cycles, where K is `word_len` (1 to KMAX) sampled at the start edge.
- R3: The sync occupies the first 6 cycles of the frame. With `cmd_sync`=1 sampled at the start edge, `line_pos` is 1,1,1,0,0,0. With `cmd_sync`=0 it is 0,0,0,1,1,1.
- R4: Data bits go out in the order they are supplied. A 1 is sent as `line_pos` high for one cycle and then low for one cycle, and a 0 as low then high. While a frame is on the line, `line_neg` is the complement of `line_pos`.
- R5: `data_req` is high for exactly 2K consecutive cycles, starting right after the sync states. Each bit is sampled from `ser_din` on the rising edge of the first cycle of its cell, and `ser_din` is ignored in the second cycle.
- R6: The last two cycles of a frame carry one parity bit, Manchester coded like a data bit. With `odd_par`=1 sampled at the start edge, the data bits plus the parity bit hold an odd number of ones. With `odd_par`=0 they hold an even number.
- R7: If `enable` is high at the rising edge ending a frame's last cycle, the next frame follows with no idle cycle between the two. If it is low there, the block returns to idle.
- R8: While `out_inh_n` is 0, both `line_pos` and `line_neg` are 1. Sequencing continues unaffected, including `data_req` timing.
- R9: `abort` sampled high on a rising edge returns the block to idle. From the next cycle on, both outputs are 0 and `data_req` is 0. A later frame then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| abort | input | 1 | Synchronous frame abort, returns to idle |
| enable | input | 1 | Frame request, also chains frames |
| cmd_sync | input | 1 | 1 selects command sync, 0 selects data sync |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| word_len | input | $clog2(KMAX+1) | Data bit count K per frame |
| ser_din | input | 1 | Serial data bit from the host |
| out_inh_n | input | 1 | Active-low line inhibit, forces both outputs high |
| data_req | output | 1 | High while data bits are being taken |
| line_pos | output | 1 | Positive-sense Manchester line output |
| line_neg | output | 1 | Negative-sense Manchester line output |

## Verification
The hardest situations to reach are a frame boundary during chaining and an abort partway through a word. Both depend on where a phase counter stands, and no port exposes it. The stimulus follows `data_req` cycle by cycle. It places the next frame's sync and parity choices, or the drop of `enable`, on the cycle after the strobe falls. It also scrambles `ser_din` in the second half of each cell, so that sampling in the wrong half shows up on the line. The abort is issued a fixed number of cycles into the data phase, so both the partial run and the return to idle are seen at the outputs.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2,
    PH_PAR  = 2'd3
  } phase_t;

  localparam int SYNC_HALVES = 6;
  localparam int SYNC_SPLIT  = 3;
endpackage

// File: rtl/mwe_parity.sv
module mwe_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic din,
  input  logic odd,
  output logic pbit
);
  logic acc_q;
  logic acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = 1'b0;
    end else if (take) begin
      acc_d = acc_q ^ din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign pbit = acc_q ^ odd;

  AST_PAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pbit == odd)); // R6
endmodule

// File: rtl/mwe_seq.sv
module mwe_seq
  import mwe_pkg::*;
#(
  parameter int KMAX = 32,
  localparam int KW = $clog2(KMAX + 1),
  localparam int CW = $clog2(2 * KMAX + SYNC_HALVES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          enable,
  input  logic          cmd_sync,
  input  logic          odd_par,
  input  logic [KW-1:0] word_len,
  input  logic          ser_din,
  input  logic          pbit,
  output logic          active,
  output logic          lvl,
  output logic          req,
  output logic          par_clr,
  output logic          par_take,
  output logic          odd_sense
);
  phase_t        ph_q, ph_d;
  logic [CW-1:0] hcnt_q, hcnt_d;
  logic [KW-1:0] k_q, k_d;
  logic          cmd_q, cmd_d;
  logic          odd_q, odd_d;
  logic          bit_q;
  logic          bit_ld;
  logic          frame_end;
  logic          start;
  logic [CW-1:0] data_last;

  assign data_last = CW'({k_q, 1'b0}) - CW'(1);
  assign frame_end = (ph_q == PH_PAR) && (hcnt_q == CW'(1));
  assign start     = enable && ((ph_q == PH_IDLE) || frame_end);
  assign bit_ld    = (ph_q == PH_DATA) && !hcnt_q[0] && !abort;

  always_comb begin
    ph_d   = ph_q;
    hcnt_d = hcnt_q;
    k_d    = k_q;
    cmd_d  = cmd_q;
    odd_d  = odd_q;
    if (abort) begin
      ph_d   = PH_IDLE;
      hcnt_d = '0;
      cmd_d  = 1'b0;
      odd_d  = 1'b0;
    end else if (start) begin
      ph_d   = PH_SYNC;
      hcnt_d = '0;
      k_d    = word_len;
      cmd_d  = cmd_sync;
      odd_d  = odd_par;
    end else begin
      case (ph_q)
        PH_SYNC: begin
          if (hcnt_q == CW'(SYNC_HALVES - 1)) begin
            ph_d   = PH_DATA;
            hcnt_d = '0;
          end else begin
            hcnt_d = hcnt_q + CW'(1);
          end
        end
        PH_DATA: begin
          if (hcnt_q == data_last) begin
            ph_d   = PH_PAR;
            hcnt_d = '0;
          end else begin
            hcnt_d = hcnt_q + CW'(1);
          end
        end
        PH_PAR: begin
          if (frame_end) begin
            ph_d   = PH_IDLE;
            hcnt_d = '0;
          end else begin
            hcnt_d = hcnt_q + CW'(1);
          end
        end
        default: begin
          hcnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      hcnt_q <= '0;
      k_q    <= '0;
      cmd_q  <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      hcnt_q <= hcnt_d;
      k_q    <= k_d;
      cmd_q  <= cmd_d;
      odd_q  <= odd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (bit_ld) begin
      bit_q <= ser_din;
    end
  end

  always_comb begin
    case (ph_q)
      PH_SYNC: lvl = cmd_q ? (hcnt_q < CW'(SYNC_SPLIT)) : (hcnt_q >= CW'(SYNC_SPLIT));
      PH_DATA: lvl = hcnt_q[0] ? ~bit_q : ser_din;
      PH_PAR:  lvl = hcnt_q[0] ? ~pbit : pbit;
      default: lvl = 1'b0;
    endcase
  end

  assign active    = (ph_q != PH_IDLE);
  assign req       = (ph_q == PH_DATA);
  assign par_clr   = abort || start;
  assign par_take  = bit_ld;
  assign odd_sense = odd_q;

  AST_SYNC_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SYNC && hcnt_q == CW'(SYNC_HALVES - 1) && !abort) |=> (ph_q == PH_DATA && hcnt_q == '0)); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!req && !active)); // R9
  AST_CHAIN_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && enable && !abort) |=> (ph_q == PH_SYNC && hcnt_q == '0)); // R7
  AST_REQ_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(ph_q) == PH_SYNC)); // R5
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && !hcnt_q[0] && !abort) |=> (ph_q == PH_DATA && hcnt_q[0])); // R4
endmodule

// File: rtl/mwe_drive.sv
module mwe_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic active,
  input  logic lvl,
  input  logic out_inh_n,
  output logic line_pos,
  output logic line_neg
);
  logic pos_q, neg_q;
  logic pos_d, neg_d;
  logic live;

  assign live = active && !abort;

  always_comb begin
    pos_d = 1'b0;
    neg_d = 1'b0;
    if (live) begin
      pos_d = lvl;
      neg_d = ~lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  assign line_pos = out_inh_n ? pos_q : 1'b1;
  assign line_neg = out_inh_n ? neg_q : 1'b1;

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_inh_n) |=> (!out_inh_n || (line_pos != line_neg))); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && out_inh_n) |=> (!out_inh_n || (!line_pos && !line_neg))); // R1
endmodule

// File: rtl/manchester_word_enc.sv
module manchester_word_enc #(
  parameter int KMAX = 32,
  localparam int KW = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          enable,
  input  logic          cmd_sync,
  input  logic          odd_par,
  input  logic [KW-1:0] word_len,
  input  logic          ser_din,
  input  logic          out_inh_n,
  output logic          data_req,
  output logic          line_pos,
  output logic          line_neg
);
  logic active, lvl, pbit, par_clr, par_take, odd_sense;

  mwe_seq #(.KMAX(KMAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort), .enable(enable),
    .cmd_sync(cmd_sync), .odd_par(odd_par), .word_len(word_len),
    .ser_din(ser_din), .pbit(pbit), .active(active), .lvl(lvl),
    .req(data_req), .par_clr(par_clr), .par_take(par_take),
    .odd_sense(odd_sense)
  );

  mwe_parity u_par (
    .clk(clk), .rst_n(rst_n), .clr(par_clr), .take(par_take),
    .din(ser_din), .odd(odd_sense), .pbit(pbit)
  );

  mwe_drive u_drv (
    .clk(clk), .rst_n(rst_n), .abort(abort), .active(active), .lvl(lvl),
    .out_inh_n(out_inh_n), .line_pos(line_pos), .line_neg(line_neg)
  );
endmodule

// File: tb/manchester_word_enc_bench.sv
module manchester_word_enc_bench;
  localparam int KMAX = 32;
  localparam int KW = $clog2(KMAX + 1);

  logic clk = 1'b0;
  logic rst_n, abort, enable, cmd_sync, odd_par, ser_din, out_inh_n;
  logic [KW-1:0] word_len;
  logic data_req, line_pos, line_neg;

  int n_chk = 0;
  int n_bad = 0;
  int run_len = 0;
  int last_run = 0;
  int cyc = 0;
  bit ign = 1'b0;
  logic exp_q[$];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  manchester_word_enc #(.KMAX(KMAX)) u_manchester_word_enc (
    .clk(clk), .rst_n(rst_n), .abort(abort), .enable(enable),
    .cmd_sync(cmd_sync), .odd_par(odd_par), .word_len(word_len),
    .ser_din(ser_din), .out_inh_n(out_inh_n), .data_req(data_req),
    .line_pos(line_pos), .line_neg(line_neg)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  // scoreboard monitor: pops one expected level per active cycle
  always @(negedge clk) begin
    cyc++;
    if (line_pos ^ line_neg) begin
      run_len++;
      if (!ign) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected line activity", 1, 0);
        end else begin
          logic e;
          e = exp_q.pop_front();
          chk(line_pos == e, "R3/R4/R6 line level", int'(line_pos), int'(e));
        end
      end
    end else begin
      if (run_len != 0) last_run = run_len;
      run_len = 0;
    end
  end

  task automatic send_chain(input int nf, input int k, input logic cmd0,
                            input logic odd0, input bit expect_line);
    logic bits[$];
    logic c, o, x;
    word_len = KW'(k);
    cmd_sync = cmd0;
    odd_par  = odd0;
    enable   = 1'b1;
    for (int f = 0; f < nf; f++) begin
      c = cmd0 ^ f[0];
      o = odd0 ^ f[1];
      bits.delete();
      x = 1'b0;
      for (int j = 0; j < k; j++) begin
        bits.push_back(next_bit());
        x ^= bits[j];
      end
      if (expect_line) begin
        for (int s = 0; s < 6; s++) exp_q.push_back(c ? (s < 3) : (s >= 3));
        for (int j = 0; j < k; j++) begin
          exp_q.push_back(bits[j]);
          exp_q.push_back(~bits[j]);
        end
        exp_q.push_back(x ^ o);
        exp_q.push_back(~(x ^ o));
      end
      while (!data_req) @(negedge clk);
      for (int h = 0; h < 2 * k; h++) begin
        ser_din = (h % 2 == 0) ? bits[h / 2] : ~bits[h / 2];
        chk(data_req == 1'b1, "R5 data_req held", int'(data_req), 1);
        if (!out_inh_n) chk(line_pos && line_neg, "R8 inhibit forces high", int'({line_pos, line_neg}), 3);
        @(negedge clk);
      end
      chk(data_req == 1'b0, "R5 data_req width 2K", int'(data_req), 0);
      if (f < nf - 1) begin
        cmd_sync = cmd0 ^ f[0] ^ 1'b1;
        odd_par  = odd0 ^ ((f + 1) >> 1 & 1) == 1;
        odd_par  = odd0 ^ (((f + 1) >> 1) % 2 == 1);
      end else begin
        enable = 1'b0;
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; abort = 1'b0; enable = 1'b0; cmd_sync = 1'b0; odd_par = 1'b0;
    ser_din = 1'b0; out_inh_n = 1'b1; word_len = '0;
    repeat (3) @(negedge clk);
    chk(!line_pos && !line_neg, "R1 reset outputs low", int'({line_pos, line_neg}), 0);
    chk(!data_req, "R1 reset req low", int'(data_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send_chain(1, 16, 1'b1, 1'b1, 1'b1);
    chk(last_run == 40, "R2 frame length K=16", last_run, 40);
    chk(exp_q.size() == 0, "R4 all bits seen", exp_q.size(), 0);

    send_chain(1, 5, 1'b0, 1'b0, 1'b1);
    chk(last_run == 18, "R2 frame length K=5", last_run, 18);

    send_chain(1, 1, 1'b1, 1'b0, 1'b1);
    chk(last_run == 10, "R2 frame length K=1", last_run, 10);

    send_chain(1, KMAX, 1'b0, 1'b1, 1'b1);
    chk(last_run == 2 * KMAX + 8, "R2 frame length K=KMAX", last_run, 2 * KMAX + 8);

    send_chain(3, 8, 1'b1, 1'b0, 1'b1);
    chk(last_run == 72, "R7 gapless chain of 3", last_run, 72);
    chk(exp_q.size() == 0, "R7 chain all levels", exp_q.size(), 0);
    chk(!line_pos && !line_neg && !data_req, "R1 idle after chain", int'({line_pos, line_neg, data_req}), 0);

    out_inh_n = 1'b0;
    ign = 1'b1;
    send_chain(1, 6, 1'b1, 1'b1, 1'b0);
    chk(line_pos && line_neg, "R8 inhibit when idle", int'({line_pos, line_neg}), 3);
    out_inh_n = 1'b1;
    @(negedge clk);
    chk(!line_pos && !line_neg, "R8 release inhibit", int'({line_pos, line_neg}), 0);
    ign = 1'b0;

    ign = 1'b1;
    word_len = KW'(10); cmd_sync = 1'b1; odd_par = 1'b0; enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    while (!data_req) @(negedge clk);
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!line_pos && !line_neg, "R9 abort outputs low", int'({line_pos, line_neg}), 0);
    chk(!data_req, "R9 abort req low", int'(data_req), 0);
    repeat (3) @(negedge clk);
    chk(!line_pos && !line_neg && !data_req, "R9 stays idle", int'({line_pos, line_neg, data_req}), 0);
    exp_q.delete();
    ign = 1'b0;

    send_chain(1, 4, 1'b0, 1'b1, 1'b1);
    chk(last_run == 16, "R9 frame after abort", last_run, 16);
    chk(exp_q.size() == 0, "R9 all levels after abort", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule